// File: doc/BRIEF.md
# Local Interrupt Controller Mode Register

This block is the per-processor control register that decides whether a local interrupt controller is switched off, running in its legacy memory-mapped mode, or running in its extended mode. It presents a 64-bit value made of a fixed base-address field, a bootstrap-processor flag, an extended-mode bit and a global enable bit. Software changes only the two mode bits, through a single-cycle write strobe. Every other bit of the written word is dropped.

A write that asks for a new mode is checked against a restricted transition graph. A legal change updates the register. An illegal one leaves the register as it was and raises a one-cycle error pulse. Turning the controller off sends a one-cycle soft-reset request to the rest of the controller. Entering extended mode loads the extended identifier with the processor number and loads the logical destination value derived from it. The processor number and the highest supported mode are set by parameters.

Top module: `lic_mode_reg`

## Requirements
- R1: After reset the register reads base address 0xFEE00000 in bits 31:12, zeros in bits 63:32, and keeps that base field constant. The enable flag sits in bit 11, the extended flag in bit 10 and the bootstrap flag in bit 8.
- R2: The bootstrap flag (bit 8) is 1 exactly when the processor number parameter is 0, and it never changes.
- R3: At reset the enable bit is 1 unless the highest supported mode parameter is 0 (no controller). The extended bit is 0. The mode output encodes 0 = disabled (enable 0), 1 = legacy (enable 1, extended 0), 2 = extended (both 1).
- R4: A request for legacy mode (bit 11 = 1, bit 10 = 0) is accepted only when the current mode is disabled.
- R5: A request for extended mode (bits 11 and 10 both 1) is accepted only when the current mode is legacy and the highest supported mode parameter is 2.
- R6: A request for disabled mode (bit 11 = 0, bit 10 = 0) from another mode is always accepted. It clears both mode bits and clears the extended identifier and logical destination outputs. It also pulses the soft-reset output for exactly the cycle after the write.
- R7: Entering extended mode sets the extended identifier to the processor number. It sets the logical destination to ((id & 0xFFFF0) << 16) | (1 << (id & 0xF)), computed in 32 bits.
- R8: A write that requests the current mode changes nothing and raises neither the error nor the soft-reset output.
- R9: A write with bit 11 = 0 and bit 10 = 1 is illegal in every mode.
- R10: A rejected write leaves all outputs except the error unchanged. The error output is 1 in the cycle after that write only.
- R11: Bits of the written word other than 11 and 10 have no effect, including the base-address and bootstrap fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 64 | Written word; only bits 11 and 10 are used |
| base_q | output | 64 | Current register value |
| mode | output | 2 | Current mode: 0 disabled, 1 legacy, 2 extended |
| wr_err | output | 1 | One-cycle pulse for a rejected write |
| soft_rst | output | 1 | One-cycle pulse when the controller is disabled |
| ext_id | output | 32 | Identifier loaded on entering extended mode |
| ext_ldr | output | 32 | Logical destination loaded on entering extended mode |

## Verification
The same write sequence drives two instances: one with a nonzero processor number and full mode support, and one with processor number 0 and no controller. The sequence requests every mode from every reachable mode, so each edge of the transition graph is tried in both its legal and its rejected form. Same-mode writes carrying junk in the base and bootstrap fields separate a write that is ignored from one that is taken. Back-to-back writes and the encoding with extended set and enable clear show that the error and soft-reset pulses last exactly one cycle and track the right write.

// File: rtl/lic_mode_reg.sv
module lic_mode_reg #(
  parameter logic [31:0] CPU_NUM   = 32'd0,
  parameter int          MAX_MODE  = 2,
  parameter logic [63:0] BASE_ADDR = 64'h0000_0000_FEE0_0000,
  parameter int          BSP_BIT   = 8,
  parameter int          EXT_BIT   = 10,
  parameter int          EN_BIT    = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  output logic [63:0] base_q,
  output logic [1:0]  mode,
  output logic        wr_err,
  output logic        soft_rst,
  output logic [31:0] ext_id,
  output logic [31:0] ext_ldr
);
  localparam logic [1:0]  M_DIS = 2'd0;
  localparam logic [1:0]  M_LEG = 2'd1;
  localparam logic [1:0]  M_EXT = 2'd2;
  localparam logic        IS_BSP = (CPU_NUM == 32'd0);
  localparam logic        EN_RST = (MAX_MODE != 0);
  localparam logic        EXT_OK = (MAX_MODE == 2);
  localparam logic [63:0] FIXED = BASE_ADDR | ({63'd0, IS_BSP} << BSP_BIT);
  localparam logic [31:0] LDR_VAL = ((CPU_NUM & 32'h000F_FFF0) << 16) |
                                    (32'd1 << CPU_NUM[3:0]);

  logic en_q, ext_q, err_q, srst_q;
  logic [31:0] id_q, ldr_q;

  logic req_en, req_ext, req_bad, chg, ok, take;
  logic [1:0] req_mode;

  assign req_en   = wr_data[EN_BIT];
  assign req_ext  = wr_data[EXT_BIT];
  assign req_bad  = req_ext & ~req_en;
  assign req_mode = !req_en ? M_DIS : (req_ext ? M_EXT : M_LEG);

  assign mode = !en_q ? M_DIS : (ext_q ? M_EXT : M_LEG);

  always_comb begin
    case (req_mode)
      M_DIS:   ok = 1'b1;
      M_LEG:   ok = (mode == M_DIS);
      default: ok = (mode == M_LEG) && EXT_OK;
    endcase
  end

  assign chg  = wr_en & ~req_bad & (req_mode != mode);
  assign take = chg & ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= EN_RST;
      ext_q  <= 1'b0;
      err_q  <= 1'b0;
      srst_q <= 1'b0;
      id_q   <= '0;
      ldr_q  <= '0;
    end else begin
      err_q  <= wr_en & (req_bad | (chg & ~ok));
      srst_q <= take & (req_mode == M_DIS);
      if (take) begin
        en_q  <= req_en;
        ext_q <= req_ext;
        if (req_mode == M_EXT) begin
          id_q  <= CPU_NUM;
          ldr_q <= LDR_VAL;
        end else if (req_mode == M_DIS) begin
          id_q  <= '0;
          ldr_q <= '0;
        end
      end
    end
  end

  assign base_q   = FIXED | ({63'd0, en_q} << EN_BIT) | ({63'd0, ext_q} << EXT_BIT);
  assign wr_err   = err_q;
  assign soft_rst = srst_q;
  assign ext_id   = id_q;
  assign ext_ldr  = ldr_q;

  a_r4_legacy_src: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LEG && $past(mode) != M_LEG) |-> $past(mode) == M_DIS);

  a_r5_ext_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == M_EXT) |-> ($past(mode) == M_LEG && EXT_OK));

  a_r6_disable_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DIS && $past(mode) != M_DIS) |-> (soft_rst && ext_id == 32'd0));

  a_r7_ldr_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_EXT) |-> ($countones(ext_ldr[15:0]) == 1 && ext_id == CPU_NUM));

  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($stable(base_q) && !soft_rst));

  a_r1_base_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[63:12] == BASE_ADDR[63:12]);
endmodule

// File: tb/lic_mode_reg_test.sv
module lic_mode_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  always #2 clk = ~clk;

  logic [63:0] bq [2];
  logic [1:0]  md [2];
  logic        er [2];
  logic        sr [2];
  logic [31:0] id [2];
  logic [31:0] ld [2];

  lic_mode_reg #(.CPU_NUM(32'h23), .MAX_MODE(2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .base_q(bq[0]), .mode(md[0]), .wr_err(er[0]), .soft_rst(sr[0]),
    .ext_id(id[0]), .ext_ldr(ld[0]));

  lic_mode_reg #(.CPU_NUM(32'h0), .MAX_MODE(0)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .base_q(bq[1]), .mode(md[1]), .wr_err(er[1]), .soft_rst(sr[1]),
    .ext_id(id[1]), .ext_ldr(ld[1]));

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;
  int cpu  [2] = '{32'h23, 0};
  int maxm [2] = '{2, 0};
  bit m_en [2], m_ext [2], m_err [2], m_srst [2];
  logic [31:0] m_id [2], m_ld [2];

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_en[k] = (maxm[k] != 0); m_ext[k] = 0; m_err[k] = 0; m_srst[k] = 0;
        m_id[k] = 0; m_ld[k] = 0;
      end else begin
        m_err[k] = 0; m_srst[k] = 0;
        if (wr_en) begin
          int cur, req;
          cur = !m_en[k] ? 0 : (m_ext[k] ? 2 : 1);
          if (wr_data[10] && !wr_data[11]) m_err[k] = 1;             // R9
          else begin
            req = !wr_data[11] ? 0 : (wr_data[10] ? 2 : 1);
            if (req != cur) begin                                      // R8
              if (req == 0) begin                                      // R6
                m_en[k] = 0; m_ext[k] = 0; m_srst[k] = 1; m_id[k] = 0; m_ld[k] = 0;
              end else if (req == 1) begin                             // R4
                if (cur == 0) m_en[k] = 1; else m_err[k] = 1;
              end else begin                                           // R5
                if (cur == 1 && maxm[k] == 2) begin
                  m_ext[k] = 1; m_id[k] = cpu[k];
                  m_ld[k] = ((cpu[k] & 32'hFFFF0) << 16) | (32'd1 << (cpu[k] & 15));
                end else m_err[k] = 1;
              end
            end
          end
        end
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        logic [63:0] eb;
        eb = 64'hFEE0_0000 | (64'(cpu[k] == 0) << 8) | (64'(m_en[k]) << 11) | (64'(m_ext[k]) << 10);
        chk("R1/R11 base", bq[k], eb);
        chk("R3 mode", 64'(md[k]), 64'(!m_en[k] ? 0 : (m_ext[k] ? 2 : 1)));
        chk("R10 err", 64'(er[k]), 64'(m_err[k]));
        chk("R6 soft_rst", 64'(sr[k]), 64'(m_srst[k]));
        chk("R7 id", 64'(id[k]), 64'(m_id[k]));
        chk("R7 ldr", 64'(ld[k]), 64'(m_ld[k]));
      end
    end
  end

  task automatic wr(logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); wr_en = 1'b0; wr_data = '0; end
  endtask

  localparam logic [63:0] W_DIS = 64'h0, W_LEG = 64'h800, W_EXT = 64'hC00, W_BAD = 64'h400;
  localparam logic [63:0] W_JUNK_LEG = 64'hDEAD_0000_1234_5900;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R2 bsp uut", 64'(bq[0][8]), 64'd0);
    chk("R2 bsp cap", 64'(bq[1][8]), 64'd1);
    chk("R3 reset en cap", 64'(bq[1][11]), 64'd0);
    wr(W_JUNK_LEG); idle(2);  // R8 R11 on uut; R4 legal on u_cap
    wr(W_EXT); idle(2);       // R5 accepted on uut, R7 values; rejected on u_cap
    #1 chk("R7 ldr value", 64'(ld[0]), 64'h0020_0008);
    wr(W_EXT); idle(1);       // R8 same-mode
    wr(W_LEG); idle(2);       // R4 reject from extended, R10
    wr(W_BAD); idle(2);       // R9 illegal encoding
    wr(W_DIS); idle(2);       // R6 disable
    wr(W_EXT); idle(2);       // R5 reject from disabled
    wr(W_LEG); wr(W_EXT); wr(W_DIS); wr(W_BAD); idle(3);  // back-to-back pulses
    wr(W_DIS | 64'hFFFF_FFFF_0000_F1FF); idle(2);         // R11 junk with disable code
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #20000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule